// File: doc/BRIEF.md
# Microcoded Accumulator Datapath

This block is the register-transfer half of a small accumulator machine. Every clock it takes three 3-bit microoperation groups, decodes each group on its own, and applies up to three register transfers at once. The state it holds is an 11-bit address register, an 11-bit program counter, a 16-bit data register, a 16-bit accumulator and a 2048-word by 16-bit memory. It has no sequencing logic. An external microprogram sequencer drives the three groups each cycle and reads back the status outputs to choose its next control address.

All transfers in one cycle read the values that the registers held before the clock edge, and all of them commit on the rising edge. Group A, group B and group C can each write the accumulator. When more than one of them does so in the same cycle, group A wins over group B, and group B wins over group C. The memory is read combinationally at the address register, so a read lands in the data register at the same edge that requests it. The data register is laid out as an instruction word: bit 15 is the indirect flag, bits 14 to 11 are the opcode, and bits 10 to 0 are the address.

Top module: `acc_datapath`

## Requirements
- R1: While reset is asserted, and on release, the address register, program counter, data register and accumulator all read zero.
- R2: Group A codes that write the accumulator: 001 adds the data register modulo 2^16, 010 clears it, 011 adds one modulo 2^16, 100 copies the data register into it.
- R3: Group A code 101 loads the address register from data bits 10:0. Code 110 loads it from the program counter. Code 111 writes the data register into memory at the address register.
- R4: Group B codes that write the accumulator: 001 subtracts the data register modulo 2^16, 010 takes the bitwise OR with the data register, 011 takes the bitwise AND with the data register.
- R5: Group B codes that write the data register: 100 loads the memory word at the address register, 101 copies the accumulator, 110 adds one modulo 2^16, 111 replaces bits 10:0 with the program counter and keeps bits 15:11.
- R6: Group C codes that write the accumulator: 001 takes the bitwise XOR with the data register, 010 inverts it, 011 shifts it left by one, 100 shifts it right by one. Both shifts fill the vacated bit with 0.
- R7: Group C code 101 adds one to the program counter modulo 2048, and code 110 loads the program counter from the address register. Code 111 changes nothing.
- R8: Every transfer in a cycle reads pre-edge values. Group A code 100 together with group B code 101 swaps the accumulator and the data register.
- R9: When several groups write the accumulator in one cycle, the group A result is kept over group B, and the group B result is kept over group C.
- R10: opcode_o shows data bits 14:11, indirect_o shows data bit 15, acc_sign_o shows accumulator bit 15, and acc_zero_o is 1 exactly when the accumulator is zero.
- R11: Code 000 in all three groups leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| grp_a_i | input | 3 | Group A microoperation code |
| grp_b_i | input | 3 | Group B microoperation code |
| grp_c_i | input | 3 | Group C microoperation code |
| addr_reg_o | output | 11 | Address register |
| pcnt_o | output | 11 | Program counter |
| data_reg_o | output | 16 | Data register |
| acc_o | output | 16 | Accumulator |
| opcode_o | output | 4 | Opcode field of the data register |
| indirect_o | output | 1 | Indirect flag of the data register |
| acc_sign_o | output | 1 | Accumulator sign bit |
| acc_zero_o | output | 1 | Accumulator is zero |

## Verification
Two kinds of event can fall into the same cycle: a swap, where the accumulator and the data register each load from the other, and a contest, where two or three groups all write the accumulator. Directed steps cause both on purpose. One step drives group A 100 with group B 101. Other steps drive clear, subtract and XOR together, and OR with invert together. A long run of random codes then produces many more overlaps. A bench model computes every next value from the pre-edge state in the stated priority order, and the bench compares it against all four registers and the status outputs after each edge.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

    parameter int DP_DATA_W  = 16;
    parameter int DP_ADDR_W  = 11;
    parameter int DP_FIELD_W = 3;

    localparam int DP_CODES  = 1 << DP_FIELD_W;
    localparam int GA_LINES  = DP_CODES - 1;
    localparam int GB_LINES  = DP_CODES - 1;
    localparam int GC_LINES  = DP_CODES - 2;

    typedef enum logic [DP_FIELD_W-1:0] {
        GA_NOP   = 3'd0,
        GA_ADD   = 3'd1,
        GA_CLR   = 3'd2,
        GA_INC   = 3'd3,
        GA_LDDR  = 3'd4,
        GA_ARDR  = 3'd5,
        GA_ARPC  = 3'd6,
        GA_WRITE = 3'd7
    } grp_a_e;

    typedef enum logic [DP_FIELD_W-1:0] {
        GB_NOP   = 3'd0,
        GB_SUB   = 3'd1,
        GB_OR    = 3'd2,
        GB_AND   = 3'd3,
        GB_READ  = 3'd4,
        GB_DRAC  = 3'd5,
        GB_INCDR = 3'd6,
        GB_DRPC  = 3'd7
    } grp_b_e;

    typedef enum logic [DP_FIELD_W-1:0] {
        GC_NOP   = 3'd0,
        GC_XOR   = 3'd1,
        GC_NOT   = 3'd2,
        GC_SHL   = 3'd3,
        GC_SHR   = 3'd4,
        GC_INCPC = 3'd5,
        GC_PCAR  = 3'd6,
        GC_RSVD  = 3'd7
    } grp_c_e;

endpackage

// File: rtl/acc_field_decoder.sv
module acc_field_decoder #(
    parameter int SEL_W = 3,
    parameter int LINES = 7
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [LINES:1]   line_o
);

    // Line 0 (no-op) needs no control wire; codes above LINES drive nothing.
    for (genvar g = 1; g <= LINES; g++) begin : g_line
        assign line_o[g] = (sel_i == SEL_W'(g));
    end

endmodule

// File: rtl/acc_word_mem.sv
module acc_word_mem #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            words_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = words_q[addr_i];

endmodule

// File: rtl/acc_ac_unit.sv
module acc_ac_unit
    import acc_dp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] acc_q_i,
    input  logic [DATA_W-1:0] dr_q_i,
    input  logic [GA_LINES:1] ga_line_i,
    input  logic [GB_LINES:1] gb_line_i,
    input  logic [GC_LINES:1] gc_line_i,
    output logic [DATA_W-1:0] acc_d_o
);

    logic [DATA_W-1:0] res_a, res_b, res_c;
    logic              hit_a, hit_b, hit_c;

    always_comb begin
        hit_a = 1'b1;
        res_a = acc_q_i;
        if (ga_line_i[GA_ADD]) begin
            res_a = acc_q_i + dr_q_i;
        end else if (ga_line_i[GA_CLR]) begin
            res_a = '0;
        end else if (ga_line_i[GA_INC]) begin
            res_a = acc_q_i + DATA_W'(1);
        end else if (ga_line_i[GA_LDDR]) begin
            res_a = dr_q_i;
        end else begin
            hit_a = 1'b0;
        end
    end

    always_comb begin
        hit_b = 1'b1;
        res_b = acc_q_i;
        if (gb_line_i[GB_SUB]) begin
            res_b = acc_q_i - dr_q_i;
        end else if (gb_line_i[GB_OR]) begin
            res_b = acc_q_i | dr_q_i;
        end else if (gb_line_i[GB_AND]) begin
            res_b = acc_q_i & dr_q_i;
        end else begin
            hit_b = 1'b0;
        end
    end

    always_comb begin
        hit_c = 1'b1;
        res_c = acc_q_i;
        if (gc_line_i[GC_XOR]) begin
            res_c = acc_q_i ^ dr_q_i;
        end else if (gc_line_i[GC_NOT]) begin
            res_c = ~acc_q_i;
        end else if (gc_line_i[GC_SHL]) begin
            res_c = {acc_q_i[DATA_W-2:0], 1'b0};
        end else if (gc_line_i[GC_SHR]) begin
            res_c = {1'b0, acc_q_i[DATA_W-1:1]};
        end else begin
            hit_c = 1'b0;
        end
    end

    // Fixed priority between groups: A over B over C.
    always_comb begin
        if (hit_a) begin
            acc_d_o = res_a;
        end else if (hit_b) begin
            acc_d_o = res_b;
        end else if (hit_c) begin
            acc_d_o = res_c;
        end else begin
            acc_d_o = acc_q_i;
        end
    end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_dp_pkg::*;
#(
    parameter int DATA_W  = DP_DATA_W,
    parameter int ADDR_W  = DP_ADDR_W,
    parameter int FIELD_W = DP_FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FIELD_W-1:0] grp_a_i,
    input  logic [FIELD_W-1:0] grp_b_i,
    input  logic [FIELD_W-1:0] grp_c_i,
    output logic [ADDR_W-1:0] addr_reg_o,
    output logic [ADDR_W-1:0] pcnt_o,
    output logic [DATA_W-1:0] data_reg_o,
    output logic [DATA_W-1:0] acc_o,
    output logic [DATA_W-ADDR_W-2:0] opcode_o,
    output logic              indirect_o,
    output logic              acc_sign_o,
    output logic              acc_zero_o
);

    localparam int OPC_W = DATA_W - ADDR_W - 1;
    localparam int HI_W  = DATA_W - ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] ar;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] dr;
        logic [DATA_W-1:0] ac;
    } dp_regs_t;

    dp_regs_t          regs_d, regs_q;
    logic [GA_LINES:1] ga_line;
    logic [GB_LINES:1] gb_line;
    logic [GC_LINES:1] gc_line;
    logic [DATA_W-1:0] acc_next;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_we;

    acc_field_decoder #(.SEL_W(FIELD_W), .LINES(GA_LINES)) i_dec_a (
        .sel_i  (grp_a_i),
        .line_o (ga_line)
    );

    acc_field_decoder #(.SEL_W(FIELD_W), .LINES(GB_LINES)) i_dec_b (
        .sel_i  (grp_b_i),
        .line_o (gb_line)
    );

    acc_field_decoder #(.SEL_W(FIELD_W), .LINES(GC_LINES)) i_dec_c (
        .sel_i  (grp_c_i),
        .line_o (gc_line)
    );

    acc_ac_unit #(.DATA_W(DATA_W)) i_ac_unit (
        .acc_q_i   (regs_q.ac),
        .dr_q_i    (regs_q.dr),
        .ga_line_i (ga_line),
        .gb_line_i (gb_line),
        .gc_line_i (gc_line),
        .acc_d_o   (acc_next)
    );

    acc_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .addr_i  (regs_q.ar),
        .wdata_i (regs_q.dr),
        .rdata_o (mem_rdata)
    );

    always_comb begin
        regs_d    = regs_q;
        regs_d.ac = acc_next;
        mem_we    = ga_line[GA_WRITE];

        if (ga_line[GA_ARDR]) begin
            regs_d.ar = regs_q.dr[ADDR_W-1:0];
        end else if (ga_line[GA_ARPC]) begin
            regs_d.ar = regs_q.pc;
        end

        if (gb_line[GB_READ]) begin
            regs_d.dr = mem_rdata;
        end else if (gb_line[GB_DRAC]) begin
            regs_d.dr = regs_q.ac;
        end else if (gb_line[GB_INCDR]) begin
            regs_d.dr = regs_q.dr + DATA_W'(1);
        end else if (gb_line[GB_DRPC]) begin
            regs_d.dr = {regs_q.dr[DATA_W-1 -: HI_W], regs_q.pc};
        end

        if (gc_line[GC_INCPC]) begin
            regs_d.pc = regs_q.pc + ADDR_W'(1);
        end else if (gc_line[GC_PCAR]) begin
            regs_d.pc = regs_q.ar;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign addr_reg_o = regs_q.ar;
    assign pcnt_o     = regs_q.pc;
    assign data_reg_o = regs_q.dr;
    assign acc_o      = regs_q.ac;
    assign opcode_o   = regs_q.dr[DATA_W-2 -: OPC_W];
    assign indirect_o = regs_q.dr[DATA_W-1];
    assign acc_sign_o = regs_q.ac[DATA_W-1];
    assign acc_zero_o = (regs_q.ac == '0);

endmodule

// File: rtl/acc_datapath_chk.sv
module acc_datapath_chk #(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 11,
    parameter int FIELD_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FIELD_W-1:0] grp_a_i,
    input logic [FIELD_W-1:0] grp_b_i,
    input logic [FIELD_W-1:0] grp_c_i,
    input logic [ADDR_W-1:0] addr_reg_o,
    input logic [ADDR_W-1:0] pcnt_o,
    input logic [DATA_W-1:0] data_reg_o,
    input logic [DATA_W-1:0] acc_o,
    input logic [DATA_W-ADDR_W-2:0] opcode_o,
    input logic              indirect_o,
    input logic              acc_sign_o,
    input logic              acc_zero_o
);

    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        grp_a_i == 3'd2 |=> acc_o == '0); // R2

    AST_AR_TAKES_PC: assert property (@(posedge clk) disable iff (!rst_n)
        grp_a_i == 3'd6 |=> addr_reg_o == $past(pcnt_o)); // R3

    AST_DR_TAKES_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        grp_b_i == 3'd5 |=> data_reg_o == $past(acc_o)); // R5

    AST_PC_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        grp_c_i == 3'd5 |=> pcnt_o == ADDR_W'($past(pcnt_o) + 1'b1)); // R7

    AST_PC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_c_i != 3'd5 && grp_c_i != 3'd6) |=> $stable(pcnt_o)); // R7

    AST_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_a_i == 3'd4 && grp_b_i == 3'd5)
        |=> (acc_o == $past(data_reg_o) && data_reg_o == $past(acc_o))); // R8

    AST_GROUP_A_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_a_i == 3'd3 && grp_b_i != 3'd0)
        |=> acc_o == DATA_W'($past(acc_o) + 1'b1)); // R9

    AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        opcode_o == data_reg_o[DATA_W-2 -: DATA_W-ADDR_W-1]
        && indirect_o == data_reg_o[DATA_W-1]
        && acc_sign_o == acc_o[DATA_W-1]
        && acc_zero_o == (acc_o == '0)); // R10

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_a_i == 3'd0 && grp_b_i == 3'd0 && grp_c_i == 3'd0)
        |=> ($stable(acc_o) && $stable(data_reg_o)
             && $stable(addr_reg_o) && $stable(pcnt_o))); // R11

endmodule

bind acc_datapath acc_datapath_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .FIELD_W (FIELD_W)
) i_acc_datapath_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .grp_a_i    (grp_a_i),
    .grp_b_i    (grp_b_i),
    .grp_c_i    (grp_c_i),
    .addr_reg_o (addr_reg_o),
    .pcnt_o     (pcnt_o),
    .data_reg_o (data_reg_o),
    .acc_o      (acc_o),
    .opcode_o   (opcode_o),
    .indirect_o (indirect_o),
    .acc_sign_o (acc_sign_o),
    .acc_zero_o (acc_zero_o)
);

// File: tb/test_acc_datapath.sv
module test_acc_datapath;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ga = '0, gb = '0, gc = '0;
    logic [10:0] ar_o, pc_o;
    logic [15:0] dr_o, ac_o;
    logic [3:0]  opc_o;
    logic        ind_o, sign_o, zero_o;

    logic [10:0] m_ar = '0, m_pc = '0;
    logic [15:0] m_dr = '0, m_ac = '0;
    logic [15:0] m_mem [0:2047];
    bit          m_ok  [0:2047];

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    acc_datapath i_acc_datapath (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp_a_i    (ga),
        .grp_b_i    (gb),
        .grp_c_i    (gc),
        .addr_reg_o (ar_o),
        .pcnt_o     (pc_o),
        .data_reg_o (dr_o),
        .acc_o      (ac_o),
        .opcode_o   (opc_o),
        .indirect_o (ind_o),
        .acc_sign_o (sign_o),
        .acc_zero_o (zero_o)
    );

    // Registers plus the R10 status view, all against the model.
    task automatic check(input string tag);
        bit bad;
        n_cmp++;
        bad = (ar_o !== m_ar) || (pc_o !== m_pc) || (dr_o !== m_dr) || (ac_o !== m_ac)
           || (opc_o !== m_dr[14:11]) || (ind_o !== m_dr[15])
           || (sign_o !== m_ac[15]) || (zero_o !== (m_ac == 16'h0));
        if (bad) begin
            n_bad++;
            $display("FAIL %s: ar=%h pc=%h dr=%h ac=%h st=%h/%b%b%b expected ar=%h pc=%h dr=%h ac=%h st=%h/%b%b%b",
                     tag, ar_o, pc_o, dr_o, ac_o, opc_o, ind_o, sign_o, zero_o,
                     m_ar, m_pc, m_dr, m_ac, m_dr[14:11], m_dr[15], m_ac[15], m_ac == 16'h0);
        end
    endtask

    task automatic step(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c,
                        input string tag);
        logic [10:0] nar, npc;
        logic [15:0] ndr, nac;
        @(negedge clk);
        ga = a; gb = b; gc = c;
        nac = m_ac;
        case (c)
            3'd1: nac = m_ac ^ m_dr;
            3'd2: nac = ~m_ac;
            3'd3: nac = m_ac << 1;
            3'd4: nac = m_ac >> 1;
            default: ;
        endcase
        case (b)
            3'd1: nac = m_ac - m_dr;
            3'd2: nac = m_ac | m_dr;
            3'd3: nac = m_ac & m_dr;
            default: ;
        endcase
        case (a)
            3'd1: nac = m_ac + m_dr;
            3'd2: nac = 16'h0;
            3'd3: nac = m_ac + 16'h1;
            3'd4: nac = m_dr;
            default: ;
        endcase
        nar = m_ar;
        if (a == 3'd5) nar = m_dr[10:0];
        if (a == 3'd6) nar = m_pc;
        ndr = m_dr;
        case (b)
            3'd4: ndr = m_mem[m_ar];
            3'd5: ndr = m_ac;
            3'd6: ndr = m_dr + 16'h1;
            3'd7: ndr = {m_dr[15:11], m_pc};
            default: ;
        endcase
        npc = m_pc;
        if (c == 3'd5) npc = m_pc + 11'h1;
        if (c == 3'd6) npc = m_ar;
        if (a == 3'd7) begin
            m_mem[m_ar] = m_dr;
            m_ok[m_ar]  = 1'b1;
        end
        m_ar = nar; m_pc = npc; m_dr = ndr; m_ac = nac;
        @(posedge clk);
        #1;
        check(tag);
    endtask

    initial begin
        #(4 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1c3a_57e1));
        repeat (3) @(posedge clk);
        #1;
        check("R1");                       // registers zero while reset is held
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1");

        step(3'd0, 3'd0, 3'd0, "R11");
        step(3'd3, 3'd0, 3'd0, "R2");      // inc
        step(3'd0, 3'd0, 3'd2, "R6");      // invert
        step(3'd0, 3'd5, 3'd0, "R5");      // DR <- AC
        step(3'd0, 3'd0, 3'd4, "R6");      // shift right, zero fill
        step(3'd1, 3'd0, 3'd0, "R2");      // add
        step(3'd0, 3'd0, 3'd3, "R6");      // shift left
        step(3'd0, 3'd1, 3'd0, "R4");      // sub
        step(3'd0, 3'd2, 3'd0, "R4");      // or
        step(3'd0, 3'd3, 3'd0, "R4");      // and
        step(3'd0, 3'd0, 3'd1, "R6");      // xor
        step(3'd0, 3'd0, 3'd5, "R7");
        step(3'd0, 3'd0, 3'd5, "R7");
        step(3'd6, 3'd0, 3'd0, "R3");      // AR <- PC
        step(3'd0, 3'd7, 3'd0, "R5");      // DR low <- PC
        step(3'd5, 3'd0, 3'd0, "R3");      // AR <- DR low
        step(3'd7, 3'd0, 3'd0, "R3");      // write memory
        step(3'd0, 3'd6, 3'd0, "R5");      // DR inc
        step(3'd0, 3'd4, 3'd0, "R5");      // read back
        step(3'd0, 3'd0, 3'd6, "R7");      // PC <- AR
        step(3'd0, 3'd0, 3'd7, "R7");      // reserved code
        step(3'd4, 3'd5, 3'd0, "R8");      // swap
        step(3'd2, 3'd1, 3'd1, "R9");      // A beats B and C
        step(3'd0, 3'd2, 3'd2, "R9");      // B beats C
        step(3'd1, 3'd6, 3'd5, "R8");      // three groups at once
        // Boundaries: all-ones values, PC wrap, accumulator wrap to zero.
        step(3'd2, 3'd0, 3'd0, "R10");
        step(3'd0, 3'd0, 3'd2, "R10");
        step(3'd0, 3'd5, 3'd0, "R5");
        step(3'd5, 3'd0, 3'd0, "R3");
        step(3'd0, 3'd0, 3'd6, "R7");
        step(3'd0, 3'd0, 3'd5, "R7");      // 0x7FF + 1 wraps to 0
        step(3'd3, 3'd0, 3'd0, "R2");      // 0xFFFF + 1 wraps to 0

        for (int i = 0; i < 4000; i++) begin
            logic [2:0] a, b, c;
            a = 3'($urandom_range(0, 7));
            b = 3'($urandom_range(0, 7));
            c = 3'($urandom_range(0, 7));
            if (b == 3'd4 && !m_ok[m_ar]) b = 3'd0;
            step(a, b, c, "R8");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule